// File: doc/BRIEF.md
# Memory Device Test Access Port

This block is the boundary-scan test port of a synchronous memory device. A serial test clock, a mode select line and a data-in line drive a sixteen-state controller. The controller steps a 3-bit instruction register and one of three data registers: a 1-bit bypass stage, a 32-bit identification register, and a boundary register. The boundary register holds a snapshot of the control pins, the address pins and the data I/O pins. Serial data leaves on a test data output, which is driven only while a shift state is active.

The block also sits between the pads and the memory core. In normal operation, control pins pass straight to the core and the core's data outputs pass straight to the pads. Under the external-test instruction, the core's control inputs are forced to a safe inactive value and the data output drivers are switched on. The values that reach the pads come from a transfer register. That register is loaded from the data-I/O part of the boundary register on each rising edge of the main memory clock. Under the float instruction, all data outputs are released to high impedance. The sample instruction has no preload stage, so its update step leaves every pin and core signal alone. All opcodes without an assignment act as bypass.

Top module: `mem_tap`

## Requirements
- R1: When `trst_n` is low, or after five consecutive rising `tck` edges with `tms` high, the controller is in its reset state and the instruction is IDCODE (001). A following data scan therefore returns the identification value.
- R2: Under IDCODE, a data scan returns the 32-bit identification value, least significant bit first. Bit 0 of that value is always 1.
- R3: An instruction scan shifts out the capture pattern 001, least significant bit first (1, 0, 0). New instruction bits enter at the most significant end.
- R4: Opcodes are 000 external test, 001 IDCODE, 010 float, 100 sample and 111 bypass. The codes 011, 101 and 110 act as bypass. Bypass selects a 1-bit stage that captures 0 and delays `tdi` by one shift.
- R5: In every boundary-register mode, capture loads bits [3:0] from the control pins, bits [11:4] from the address pins and bits [19:12] from the data I/O pins. Bit 0 is shifted out first, and `tdi` enters at bit 19.
- R6: Under sample, a full data scan including the update step leaves `pad_dq_out`, `pad_dq_oe` and `core_ctrl` at their functional values.
- R7: Under external test, `core_ctrl` equals the safe value (all ones) and `pad_dq_oe` is 1, whatever the core requests.
- R8: Under external test, `pad_dq_out` changes only on a rising `mclk` edge. That edge copies boundary bits [19:12]. Further edges with no new scan repeat the same value.
- R9: Under float, `pad_dq_oe` is 0 and the boundary register is the selected data register.
- R10: A newly shifted instruction takes effect only on leaving the update-instruction state. While it is being shifted, the previous instruction keeps control of the pads.
- R11: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is 1 only while the controller is in a shift state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Output enable for `tdo` |
| mclk | input | 1 | Main memory clock |
| pin_ctrl | input | N_CTRL | Control pin values from the pads |
| pin_addr | input | N_ADDR | Address pin values from the pads |
| pin_dq_in | input | N_DQ | Data I/O pin input values |
| core_ctrl | output | N_CTRL | Control inputs delivered to the core |
| core_dq_out | input | N_DQ | Read data from the core |
| core_dq_oe | input | 1 | Output drive request from the core |
| pad_dq_out | output | N_DQ | Data driven toward the I/O pads |
| pad_dq_oe | output | 1 | Output driver enable for the I/O pads |

## Verification
The bench loads all eight opcodes, one after another. Each opcode is paired with its own pin values, its own core drive request and its own serial pattern. The 32-bit data scan then shows which register is selected: a one-shift delay of the pattern (bypass), the fixed identification word, or twenty captured pin bits followed by the pattern. The pad checks under the same patterns tell the pass-through, forced-drive and float modes apart. Directed scans then show three more things. Two different boundary patterns reach the pads only on `mclk` edges. The sample update step leaves the pads alone. The `tdo` output moves on the falling edge rather than the rising one.

// File: rtl/mem_tap_pkg.sv
package mem_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SH, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SH, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
  } tap_state_e;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_FLOAT  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

  typedef struct packed {
    logic sel_bsr;
    logic sel_id;
    logic extest;
    logic highz;
  } tap_dec_t;

endpackage

// File: rtl/mem_tap_rst_sync.sv
module mem_tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/mem_tap_fsm.sv
module mem_tap_fsm
  import mem_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_RESET:    state_d = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:     state_d = tms ? ST_DR_SEL : ST_IDLE;
      ST_DR_SEL:   state_d = tms ? ST_IR_SEL : ST_DR_CAP;
      ST_DR_CAP:   state_d = tms ? ST_DR_EX1 : ST_DR_SH;
      ST_DR_SH:    state_d = tms ? ST_DR_EX1 : ST_DR_SH;
      ST_DR_EX1:   state_d = tms ? ST_DR_UPD : ST_DR_PAUSE;
      ST_DR_PAUSE: state_d = tms ? ST_DR_EX2 : ST_DR_PAUSE;
      ST_DR_EX2:   state_d = tms ? ST_DR_UPD : ST_DR_SH;
      ST_DR_UPD:   state_d = tms ? ST_DR_SEL : ST_IDLE;
      ST_IR_SEL:   state_d = tms ? ST_RESET  : ST_IR_CAP;
      ST_IR_CAP:   state_d = tms ? ST_IR_EX1 : ST_IR_SH;
      ST_IR_SH:    state_d = tms ? ST_IR_EX1 : ST_IR_SH;
      ST_IR_EX1:   state_d = tms ? ST_IR_UPD : ST_IR_PAUSE;
      ST_IR_PAUSE: state_d = tms ? ST_IR_EX2 : ST_IR_PAUSE;
      ST_IR_EX2:   state_d = tms ? ST_IR_UPD : ST_IR_SH;
      ST_IR_UPD:   state_d = tms ? ST_DR_SEL : ST_IDLE;
      default:     state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_d;
  end

  // Run length of consecutive high TMS samples, saturating at five.
  logic [2:0] tms_run_q;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                  tms_run_q <= 3'd0;
    else if (!tms)               tms_run_q <= 3'd0;
    else if (tms_run_q != 3'd5)  tms_run_q <= tms_run_q + 3'd1;
  end

  AST_FIVE_TMS_RESETS: assert property (@(posedge tck) disable iff (!rst_n)
    (tms_run_q == 3'd5) |-> (state == ST_RESET)); // R1

endmodule

// File: rtl/mem_tap_ir.sv
module mem_tap_ir
  import mem_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_so,
  output tap_dec_t   dec
);

  logic [IR_W-1:0] ir_sh_q, ir_sh_d;
  logic [IR_W-1:0] ir_q, ir_d;

  always_comb begin
    ir_sh_d = ir_sh_q;
    if (state == ST_IR_CAP)     ir_sh_d = IR_CAPTURE_PAT;
    else if (state == ST_IR_SH) ir_sh_d = {tdi, ir_sh_q[IR_W-1:1]};
  end

  always_comb begin
    ir_d = ir_q;
    if (state == ST_RESET)       ir_d = OP_IDCODE;
    else if (state == ST_IR_UPD) ir_d = ir_sh_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sh_q <= IR_CAPTURE_PAT;
      ir_q    <= OP_IDCODE;
    end else begin
      ir_sh_q <= ir_sh_d;
      ir_q    <= ir_d;
    end
  end

  always_comb begin
    dec = '0;
    unique case (ir_q)
      OP_EXTEST: begin dec.sel_bsr = 1'b1; dec.extest = 1'b1; end
      OP_IDCODE: dec.sel_id = 1'b1;
      OP_FLOAT:  begin dec.sel_bsr = 1'b1; dec.highz = 1'b1; end
      OP_SAMPLE: dec.sel_bsr = 1'b1;
      default:   dec = '0;
    endcase
  end

  assign ir_so = ir_sh_q[0];

  AST_RESET_LOADS_IDCODE: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |=> (ir_q == OP_IDCODE)); // R1

  AST_IR_HOLDS_OUTSIDE_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_IR_UPD && state != ST_RESET) |=> $stable(ir_q)); // R10

  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_IR_CAP) |=> (ir_sh_q == IR_CAPTURE_PAT)); // R3

endmodule

// File: rtl/mem_tap_dr.sv
module mem_tap_dr
  import mem_tap_pkg::*;
#(
  parameter int              BSR_W    = 20,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h2B7D_4C95
) (
  input  logic             tck,
  input  logic             rst_n,
  input  tap_state_e       state,
  input  logic             tdi,
  input  logic             sel_bsr,
  input  logic             sel_id,
  input  logic [BSR_W-1:0] pins,
  input  logic             ir_so,
  output logic [BSR_W-1:0] bsr_q,
  output logic             tdo,
  output logic             tdo_en
);

  logic sel_byp;
  logic cap_dr, sh_dr;
  assign sel_byp = !sel_bsr && !sel_id;
  assign cap_dr  = (state == ST_DR_CAP);
  assign sh_dr   = (state == ST_DR_SH);

  // Bypass stage
  logic byp_q, byp_d;
  always_comb begin
    byp_d = byp_q;
    if (sel_byp && cap_dr)     byp_d = 1'b0;
    else if (sel_byp && sh_dr) byp_d = tdi;
  end

  // Identification register
  logic [ID_W-1:0] id_q, id_d;
  always_comb begin
    id_d = id_q;
    if (sel_id && cap_dr)     id_d = ID_VALUE;
    else if (sel_id && sh_dr) id_d = {tdi, id_q[ID_W-1:1]};
  end

  // Boundary register, one capture/shift cell per bit
  logic [BSR_W-1:0] bsr_d;
  logic             bsr_cap, bsr_sh;
  assign bsr_cap = sel_bsr && cap_dr;
  assign bsr_sh  = sel_bsr && sh_dr;

  for (genvar i = 0; i < BSR_W; i++) begin : g_cell
    logic cell_sin;
    if (i == BSR_W - 1) begin : g_head
      assign cell_sin = tdi;
    end else begin : g_body
      assign cell_sin = bsr_q[i+1];
    end
    assign bsr_d[i] = bsr_cap ? pins[i] : (bsr_sh ? cell_sin : bsr_q[i]);
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_q  <= ID_VALUE;
      bsr_q <= '0;
    end else begin
      byp_q <= byp_d;
      id_q  <= id_d;
      bsr_q <= bsr_d;
    end
  end

  // Serial output, retimed on the falling edge
  logic dr_so, tdo_d, tdo_en_d;
  assign dr_so    = sel_bsr ? bsr_q[0] : (sel_id ? id_q[0] : byp_q);
  assign tdo_en_d = (state == ST_IR_SH) || (state == ST_DR_SH);
  assign tdo_d    = (state == ST_IR_SH) ? ir_so : dr_so;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_en <= tdo_en_d;
    end
  end

  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
    (cap_dr && sel_byp) |=> (byp_q == 1'b0)); // R4

  AST_ID_LSB_SET: assert property (@(posedge tck) disable iff (!rst_n)
    (cap_dr && sel_id) |=> id_q[0]); // R2

  AST_TDO_OFF_OUTSIDE_SHIFT: assert property (@(negedge tck) disable iff (!rst_n)
    (state != ST_IR_SH && state != ST_DR_SH) |=> !tdo_en); // R11

  AST_TDO_ON_IN_SHIFT: assert property (@(negedge tck) disable iff (!rst_n)
    (state == ST_DR_SH) |=> tdo_en); // R11

endmodule

// File: rtl/mem_tap.sv
module mem_tap
  import mem_tap_pkg::*;
#(
  parameter int                N_CTRL    = 4,
  parameter int                N_ADDR    = 8,
  parameter int                N_DQ      = 8,
  parameter logic [ID_W-1:0]   ID_VALUE  = 32'h2B7D_4C95,
  parameter logic [N_CTRL-1:0] CTRL_SAFE = {N_CTRL{1'b1}}
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  input  logic              mclk,
  input  logic [N_CTRL-1:0] pin_ctrl,
  input  logic [N_ADDR-1:0] pin_addr,
  input  logic [N_DQ-1:0]   pin_dq_in,
  output logic [N_CTRL-1:0] core_ctrl,
  input  logic [N_DQ-1:0]   core_dq_out,
  input  logic              core_dq_oe,
  output logic [N_DQ-1:0]   pad_dq_out,
  output logic              pad_dq_oe
);

  localparam int BSR_W  = N_CTRL + N_ADDR + N_DQ;
  localparam int DQ_LSB = N_CTRL + N_ADDR;

  logic       trst_sync_n, mrst_sync_n;
  tap_state_e state;
  tap_dec_t   dec;
  logic       ir_so;
  logic [BSR_W-1:0] bsr_q;

  mem_tap_rst_sync #(.STAGES(2)) u_tck_rst (
    .clk(tck), .arst_n(trst_n), .rst_n(trst_sync_n)
  );

  mem_tap_rst_sync #(.STAGES(2)) u_mclk_rst (
    .clk(mclk), .arst_n(trst_n), .rst_n(mrst_sync_n)
  );

  mem_tap_fsm u_fsm (
    .tck(tck), .rst_n(trst_sync_n), .tms(tms), .state(state)
  );

  mem_tap_ir u_ir (
    .tck(tck), .rst_n(trst_sync_n), .state(state), .tdi(tdi),
    .ir_so(ir_so), .dec(dec)
  );

  mem_tap_dr #(.BSR_W(BSR_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .rst_n(trst_sync_n), .state(state), .tdi(tdi),
    .sel_bsr(dec.sel_bsr), .sel_id(dec.sel_id),
    .pins({pin_dq_in, pin_addr, pin_ctrl}), .ir_so(ir_so),
    .bsr_q(bsr_q), .tdo(tdo), .tdo_en(tdo_en)
  );

  // Transfer register in the memory clock domain
  logic [N_DQ-1:0] xfer_q, xfer_d;
  always_comb begin
    xfer_d = xfer_q;
    if (dec.extest) xfer_d = bsr_q[DQ_LSB +: N_DQ];
  end

  always_ff @(posedge mclk or negedge mrst_sync_n) begin
    if (!mrst_sync_n) xfer_q <= '0;
    else              xfer_q <= xfer_d;
  end

  // Pad and core steering
  always_comb begin
    core_ctrl  = pin_ctrl;
    pad_dq_out = core_dq_out;
    pad_dq_oe  = core_dq_oe;
    if (dec.extest) begin
      core_ctrl  = CTRL_SAFE;
      pad_dq_out = xfer_q;
      pad_dq_oe  = 1'b1;
    end else if (dec.highz) begin
      pad_dq_oe  = 1'b0;
    end
  end

  AST_XFER_TRACKS_BOUNDARY: assert property (@(posedge mclk) disable iff (!mrst_sync_n)
    dec.extest |=> (xfer_q == $past(bsr_q[DQ_LSB +: N_DQ]))); // R8

  AST_XFER_HOLDS_OFF_EXTEST: assert property (@(posedge mclk) disable iff (!mrst_sync_n)
    !dec.extest |=> $stable(xfer_q)); // R8

endmodule

// File: tb/mem_tap_test.sv
module mem_tap_test;

  localparam logic [31:0] IDV = 32'h2B7D_4C95;

  logic tck, trst_n, tms, tdi, tdo, tdo_en, mclk;
  logic [3:0] pin_ctrl, core_ctrl;
  logic [7:0] pin_addr, pin_dq_in, core_dq_out, pad_dq_out;
  logic core_dq_oe, pad_dq_oe;

  int n_chk, n_bad;
  bit done;

  mem_tap uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .mclk(mclk), .pin_ctrl(pin_ctrl), .pin_addr(pin_addr), .pin_dq_in(pin_dq_in),
    .core_ctrl(core_ctrl), .core_dq_out(core_dq_out), .core_dq_oe(core_dq_oe),
    .pad_dq_out(pad_dq_out), .pad_dq_oe(pad_dq_oe)
  );

  initial begin
    tck = 1'b0;
    forever #10 tck = ~tck;
  end

  // kind: 0 bypass, 1 identification, 2 boundary; pad: 0 pass-through, 1 forced drive, 2 float
  typedef struct packed { logic [2:0] op; logic [1:0] kind; logic [1:0] pad; } vec_t;
  localparam vec_t VECS [0:7] = '{
    '{3'b000, 2'd2, 2'd1}, '{3'b001, 2'd1, 2'd0}, '{3'b010, 2'd2, 2'd2}, '{3'b011, 2'd0, 2'd0},
    '{3'b100, 2'd2, 2'd0}, '{3'b101, 2'd0, 2'd0}, '{3'b110, 2'd0, 2'd0}, '{3'b111, 2'd0, 2'd0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic so, output logic en);
    @(negedge tck);
    #2 tms = m; tdi = d;
    #5 so = tdo; en = tdo_en;
  endtask

  task automatic mv(input logic m);
    logic a, b;
    step(m, 1'b0, a, b);
  endtask

  task automatic settle();
    @(posedge tck);
    #1;
  endtask

  task automatic pulse_mclk();
    #3 mclk = 1'b1;
    #3 mclk = 1'b0;
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    logic en;
    mv(1); mv(1); mv(0); mv(0);
    for (int i = 0; i < 3; i++) step(i == 2, op[i], cap[i], en);
    mv(1); mv(0);
    settle();
  endtask

  task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout,
                         output logic en_all);
    logic en;
    dout = '0;
    en_all = 1'b1;
    mv(1); mv(0); mv(0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], dout[i], en);
      en_all = en_all & en;
    end
    mv(1); mv(0);
    settle();
  endtask

  initial begin
    done = 1'b0;
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0]  cap;
    logic [63:0] din, dout, exp;
    logic        en_all, so, en;
    logic [7:0]  prev;
    n_chk = 0; n_bad = 0;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; mclk = 1'b0;
    pin_ctrl = 4'h6; pin_addr = 8'h11; pin_dq_in = 8'h22;
    core_dq_out = 8'h5A; core_dq_oe = 1'b1;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    repeat (3) pulse_mclk();
    repeat (4) mv(1);
    mv(0);
    settle();

    // R1: reset state at the ports, then IDCODE selected
    chk("R1 reset pads", {60'(tdo_en), core_ctrl}, {60'(0), 4'h6});
    chk("R1 reset pass-through", {56'(pad_dq_oe), pad_dq_out}, {56'(1), 8'h5A});
    scan_dr(64'h0, 32, dout, en_all);
    chk("R1 reset instruction is IDCODE", 64'(dout[31:0]), 64'(IDV));

    // Table walk over every opcode
    for (int v = 0; v < 8; v++) begin
      pin_ctrl    = 4'(v * 3 + 1);
      pin_addr    = 8'(8'h5A ^ (v * 37));
      pin_dq_in   = 8'(8'hC3 + v * 19);
      core_dq_out = 8'(8'h96 ^ v);
      core_dq_oe  = (v != 5);
      load_ir(VECS[v].op, cap);
      chk("R3 capture pattern", 64'(cap), 64'(3'b001));
      case (VECS[v].pad)
        2'd1:    chk("R7 forced drive", {59'(pad_dq_oe), core_ctrl}, {59'(1), 4'hF});
        2'd2:    chk("R9 float", {59'(pad_dq_oe), core_ctrl}, {59'(0), pin_ctrl});
        default: chk("R4 pass-through", {51'(pad_dq_oe), pad_dq_out, core_ctrl},
                     {51'(core_dq_oe), core_dq_out, pin_ctrl});
      endcase
      din = {32'h0, 32'(32'hF0E1D2C3 ^ (32'h11111111 * v))};
      scan_dr(din, 32, dout, en_all);
      case (VECS[v].kind)
        2'd2: begin
          exp = {32'h0, din[11:0], pin_dq_in, pin_addr, pin_ctrl};
          chk("R5 boundary capture", 64'(dout[31:0]), exp);
        end
        2'd1: chk("R2 identification", 64'(dout[31:0]), 64'(IDV));
        default: begin
          exp = {32'h0, din[30:0], 1'b0};
          chk("R4 bypass", 64'(dout[31:0]), exp);
        end
      endcase
      chk("R11 tdo_en during shift", 64'(en_all), 64'(1));
    end

    // R6: sample update step touches nothing
    pin_ctrl = 4'h9; core_dq_out = 8'h3C; core_dq_oe = 1'b1;
    load_ir(3'b100, cap);
    scan_dr(64'hFFFF_FFFF_0000_FFFF, 32, dout, en_all);
    pulse_mclk();
    chk("R6 sample update", {51'(pad_dq_oe), pad_dq_out, core_ctrl}, {51'(1), 8'h3C, 4'h9});

    // R8: transfer only on mclk edges
    load_ir(3'b000, cap);
    prev = pad_dq_out;
    din = 64'h0000_0000_A7FF_FFFF;
    scan_dr(din, 32, dout, en_all);
    chk("R8 no transfer without mclk", 64'(pad_dq_out), 64'(prev));
    pulse_mclk();
    chk("R8 first mclk edge", 64'(pad_dq_out), 64'(din[31:24]));
    pulse_mclk();
    chk("R8 repeated mclk edge", 64'(pad_dq_out), 64'(din[31:24]));
    din = 64'h0000_0000_4E00_0000;
    scan_dr(din, 32, dout, en_all);
    chk("R8 second scan held", 64'(pad_dq_out), 64'(8'hA7));
    pulse_mclk();
    chk("R8 second pattern", 64'(pad_dq_out), 64'(din[31:24]));

    // R10: old instruction rules while the new one shifts in
    mv(1); mv(1); mv(0); mv(0);
    step(0, 1'b0, so, en);
    step(0, 1'b1, so, en);
    chk("R10 old instruction during shift", 64'(pad_dq_oe), 64'(1));
    step(1, 1'b0, so, en);
    mv(1);
    chk("R10 still old in update state", 64'(pad_dq_oe), 64'(1));
    mv(0);
    settle();
    chk("R10 new instruction after update", 64'(pad_dq_oe), 64'(0));

    // R11: tdo moves on the falling edge
    load_ir(3'b001, cap);
    mv(1); mv(0); mv(0);
    step(0, 1'b0, so, en);
    chk("R11 first id bit", {62'(en), so}, {62'(1), 1'b1});
    @(posedge tck); #2;
    chk("R11 tdo held past rising edge", 64'(tdo), 64'(1));
    @(negedge tck); #2;
    chk("R11 tdo after falling edge", 64'(tdo), 64'(0));
    mv(1); mv(1); mv(0);
    step(0, 1'b0, so, en);
    chk("R11 tdo_en off in idle", 64'(en), 64'(0));

    // R1: five TMS-high clocks return to IDCODE
    load_ir(3'b111, cap);
    repeat (5) mv(1);
    mv(0);
    settle();
    scan_dr(64'h0, 32, dout, en_all);
    chk("R1 tms reset gives IDCODE", 64'(dout[31:0]), 64'(IDV));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule